// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects interrupt requests from four GPIO bank summary lines and six peripheral lines into one ten-bit status word. It then drives a single interrupt request to the next level up. The bank lines take the lowest status positions, A through D in order, and the peripheral lines follow from bit 4 upward in ascending order. A status word of all zeros means nothing is pending.

Software sees two 16-bit registers through a small register port: the status word, which is read-only, and an enable word. Bit 0 of the enable word is the global enable. Bits 1 to 6 each enable one peripheral source, and a 1 means enabled. Bank lines are always enabled at this level because each bank masks its own pins. The upstream request is a level that software treats as a rising-edge event. It stays high while any enabled status bit is set and drops once they all clear, so the next event gives a fresh rising edge.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status word reads 0, the enable word reads 0 and `irq_req` is low.
- R2: Status bits 0 to 3 follow `bank_irq[0]` to `bank_irq[3]` with one clock of latency.
- R3: Status bits 4 to 9 follow `src_irq[0]` to `src_irq[5]` as levels, with one clock of latency.
- R4: Status bits 15 to 10 and enable bits 15 to 7 always read 0.
- R5: A write with `reg_sel`=0, the status address, changes neither the status word nor the enable word.
- R6: A write with `reg_sel`=1 stores `reg_wdata[6:0]` into the enable word, and the stored value reads back at once.
- R7: `irq_req` is 1 exactly when enable bit 0 is 1 and either some status bit 0..3 is set, or some status bit 4+k is set while enable bit 1+k is set.
- R8: While enable bit 0 is 0, `irq_req` stays low whatever the status word holds.
- R9: A peripheral source whose enable bit is 0 never raises `irq_req`. Bank bits raise it whatever enable bits 1 to 6 hold.
- R10: `irq_req` falls once all enabled status bits clear, and it rises again when a new enabled event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 is status, 1 is enable |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| bank_irq | input | 4 | GPIO bank summary lines, A to D |
| src_irq | input | 6 | Peripheral interrupt lines |
| irq_req | output | 1 | Upstream interrupt request |

## Verification
A wrong enable word shows up on the first read of the enable register. It also shows on `irq_req` in the same cycle that a status bit it should gate is set. A wrong status capture shows on the status read one clock after the input changes. The bench compares both against values it computes arithmetically. It sweeps every input pattern and every enable pattern, so a single misrouted or misgated bit cannot stay hidden.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int BANKS = 4,
  parameter int SRCS  = 6,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [BANKS-1:0] bank_irq,
  input  logic [SRCS-1:0]  src_irq,
  output logic          irq_req
);
  localparam int ST_W = BANKS + SRCS;
  localparam int EN_W = SRCS + 1;

  logic [ST_W-1:0] status_q;
  logic [EN_W-1:0] enable_q;
  logic [ST_W-1:0] gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= {src_irq, bank_irq};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                enable_q <= '0;
    else if (reg_wr && reg_sel) enable_q <= reg_wdata[EN_W-1:0];
  end

  assign gate      = {enable_q[EN_W-1:1], {BANKS{1'b1}}};
  assign irq_req   = enable_q[0] && |(status_q & gate);
  assign reg_rdata = reg_sel ? DW'(enable_q) : DW'(status_q);

  AST_GLOBAL_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q[0] |-> !irq_req); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_req); // R10
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> $stable(enable_q)); // R5
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(enable_q)); // R6
  AST_BANK_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q[0] && |status_q[BANKS-1:0]) |-> irq_req); // R9
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_sel = 0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  bank_irq = '0;
  logic [5:0]  src_irq = '0;
  logic        irq_req;
  int checks = 0;
  int bad = 0;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bank_irq(bank_irq),
    .src_irq(src_irq), .irq_req(irq_req)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic sel, output logic [15:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  function automatic logic exp_irq(input logic [6:0] m, input logic [3:0] b, input logic [5:0] s);
    return m[0] && ((b != 0) || ((s & m[6:1]) != 0));
  endfunction

  task automatic apply(input logic [3:0] b, input logic [5:0] s);
    @(negedge clk);
    bank_irq = b; src_irq = s;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD*200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_reg(0, d); check("R1 status", d, 16'h0);
    rd_reg(1, d); check("R1 enable", d, 16'h0);
    check("R1 irq", {15'b0, irq_req}, 16'h0);

    wr_reg(1, 16'hFFFF);
    rd_reg(1, d); check("R6 R4 enable readback", d, 16'h007F);
    wr_reg(1, 16'h0055);
    rd_reg(1, d); check("R6 enable readback", d, 16'h0055);

    wr_reg(0, 16'hFFFF);
    rd_reg(1, d); check("R5 enable after status write", d, 16'h0055);
    rd_reg(0, d); check("R5 status after status write", d, 16'h0000);

    wr_reg(1, 16'h007F);
    for (int v = 0; v < 1024; v++) begin
      apply(v[3:0], v[9:4]);
      rd_reg(0, d); check("R2 R3 R4 status", d, 16'(v));
      check("R7 irq full enable", {15'b0, irq_req},
            {15'b0, exp_irq(7'h7F, v[3:0], v[9:4])});
    end

    for (int m = 0; m < 128; m++) begin
      wr_reg(1, 16'(m));
      for (int p = 0; p < 16; p++) begin
        logic [3:0] b;
        logic [5:0] s;
        b = (p[3:2] == 2'b11) ? 4'(1 << p[1:0]) : 4'h0;
        s = 6'(1 << (p % 6)) | (p[3] ? 6'h20 : 6'h0);
        if (p == 0) s = 6'h0;
        apply(b, s);
        if (m[0] == 0)
          check("R8 global off", {15'b0, irq_req}, 16'h0);
        else if (b == 0)
          check("R9 per-source gate", {15'b0, irq_req},
                {15'b0, exp_irq(7'(m), b, s)});
        else
          check("R9 bank always on", {15'b0, irq_req}, 16'h1);
      end
    end

    wr_reg(1, 16'h0003);
    apply(4'h0, 6'h01);
    check("R10 first rise", {15'b0, irq_req}, 16'h1);
    apply(4'h0, 6'h00);
    check("R10 drop", {15'b0, irq_req}, 16'h0);
    apply(4'h0, 6'h02);
    check("R10 disabled source stays low", {15'b0, irq_req}, 16'h0);
    apply(4'h0, 6'h01);
    check("R10 second rise", {15'b0, irq_req}, 16'h1);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule